// File: doc/BRIEF.md
# Masked Sector Scan Comparator

This block searches one track of a disk for a sector that stands in a chosen relation to a search key. Before a scan, the key is loaded into a local buffer that is one sector long. Any key byte equal to 0xFF is a wildcard and takes no part in the comparison. A scan command carries a mode code that selects one of three tests: equal, disk-not-greater, or disk-not-less.

Once started, the block takes sector data as a byte stream, one byte per valid cycle. A first-byte marker and a sector identifier come with the first byte of each sector. For each sector the block works out one relation between the sector and the key, then checks that relation against the selected mode. It stops at the first sector that meets the mode, reports that sector's identifier and raises a found flag. If a full track of sectors goes by with no match, it finishes with found low. The hit flag is meant to drive a status bit that a test-and-branch operation can read.

Top module: `scan_cmp`

## Requirements
- R1: After reset, scan_busy, scan_done, scan_found and scan_err are all 0.
- R2: Mode codes are 0x00 (equal), 0x01 (disk not greater than key) and 0x02 (disk not less than key). A start while idle with a code of 0x03 or above sets scan_err=1 and scan_done=1 on the next cycle, with scan_found=0 and scan_busy=0. No scan takes place.
- R3: A key byte of 0xFF never affects the result. An all-0xFF key matches the first sector in every mode.
- R4: A sector's relation is set by the first (lowest-indexed) non-wildcard byte where the disk byte differs from the key byte. The compare is unsigned, with the disk byte on the left. Later bytes have no effect.
- R5: In equal mode, a sector matches only when every non-wildcard byte equals the key.
- R6: In mode 0x01, a sector matches when its relation is less or equal.
- R7: In mode 0x02, a sector matches when its relation is greater or equal.
- R8: On the cycle after the last byte of the first matching sector, scan_found=1, scan_done=1, scan_busy=0, and hit_sector holds that sector's identifier. Later sectors leave found and hit_sector unchanged.
- R9: If TRACK_SECTORS complete sectors go by with no match, scan_done=1 and scan_found=0.
- R10: A valid start while idle gives scan_busy=1, scan_done=0, scan_found=0 and scan_err=0 on the next cycle, even if a previous scan had found a match.
- R11: A start pulse while busy is ignored, whatever its mode code. The running scan goes on, and scan_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Write strobe for the key buffer |
| key_addr | input | 8 | Key byte index |
| key_data | input | 8 | Key byte value |
| scan_start | input | 1 | Start command pulse |
| scan_mode | input | 8 | Mode code, sampled with scan_start |
| strm_valid | input | 1 | A sector byte is present |
| strm_first | input | 1 | Marks byte 0 of a sector |
| strm_sector | input | 6 | Sector identifier, sampled with strm_first |
| strm_data | input | 8 | Sector byte |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Scan finished or rejected |
| scan_found | output | 1 | A sector met the mode |
| scan_err | output | 1 | Mode code rejected |
| hit_sector | output | 6 | Identifier of the matching sector |

## Verification
A wrong relation register or a bad wildcard decision shows up as a wrong scan_found or hit_sector. It appears on the cycle after the last byte of the affected sector, so each scan pins a fault to one sector boundary. Mixed keys, where a wildcard or an earlier difference masks a later one, expose a wrong priority or signed compare within that same sector. A wrong sector counter shows up as scan_done rising one sector early or late when no sector matches.

// File: rtl/scan_cmp_pkg.sv
package scan_cmp_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] WILDCARD = 8'hFF;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2
    } rel_e;

    typedef enum logic [1:0] {
        MODE_EQ  = 2'd0,
        MODE_LE  = 2'd1,
        MODE_GE  = 2'd2,
        MODE_BAD = 2'd3
    } mode_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic found;
        logic err;
    } flags_t;

    function automatic mode_e decode_mode(input logic [BYTE_W-1:0] code);
        case (code)
            8'h00:   return MODE_EQ;
            8'h01:   return MODE_LE;
            8'h02:   return MODE_GE;
            default: return MODE_BAD;
        endcase
    endfunction

    function automatic rel_e byte_rel(input logic [BYTE_W-1:0] disk,
                                      input logic [BYTE_W-1:0] key);
        if (key == WILDCARD || disk == key) return REL_EQ;
        else if (disk < key)                return REL_LT;
        else                                return REL_GT;
    endfunction

    function automatic logic rel_meets(input mode_e m, input rel_e r);
        case (m)
            MODE_EQ: return r == REL_EQ;
            MODE_LE: return r != REL_GT;
            MODE_GE: return r != REL_LT;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scan_key_buf.sv
module scan_key_buf #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                waddr,
    input  logic [scan_cmp_pkg::BYTE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]                raddr,
    output logic [scan_cmp_pkg::BYTE_W-1:0]  rdata
);
    logic [scan_cmp_pkg::BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/scan_sector_rel.sv
module scan_sector_rel
    import scan_cmp_pkg::*;
#(
    parameter int SECTOR_BYTES = 256,
    parameter int SEC_ID_W     = 6,
    parameter int IDX_W        = $clog2(SECTOR_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic [SEC_ID_W-1:0] in_sector,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic [BYTE_W-1:0]   key_byte,
    output logic [IDX_W-1:0]    key_idx,
    output logic                sec_end,
    output rel_e                sec_rel,
    output logic [SEC_ID_W-1:0] sec_id
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

    logic [IDX_W-1:0]    idx_q;
    logic                in_sec_q;
    rel_e                rel_q;
    logic [SEC_ID_W-1:0] id_q;

    logic accept;
    rel_e base_rel;
    rel_e step_rel;

    always_comb begin
        key_idx  = in_first ? '0 : idx_q;
        accept   = enable && in_valid && (in_first || in_sec_q);
        base_rel = in_first ? REL_EQ : rel_q;
        step_rel = byte_rel(in_data, key_byte);
        sec_rel  = (base_rel != REL_EQ) ? base_rel : step_rel;
        sec_end  = accept && (key_idx == LAST_IDX);
        sec_id   = in_first ? in_sector : id_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            in_sec_q <= 1'b0;
            rel_q    <= REL_EQ;
            id_q     <= '0;
        end else if (!enable) begin
            in_sec_q <= 1'b0;
        end else if (accept) begin
            rel_q    <= sec_rel;
            idx_q    <= key_idx + 1'b1;
            in_sec_q <= !sec_end;
            if (in_first) id_q <= in_sector;
        end
    end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_cmp_pkg::*;
#(
    parameter int TRACK_SECTORS = 24,
    parameter int SEC_ID_W      = 6,
    parameter int CNT_W         = $clog2(TRACK_SECTORS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BYTE_W-1:0]   mode_code,
    input  logic                sec_end,
    input  rel_e                sec_rel,
    input  logic [SEC_ID_W-1:0] sec_id,
    output flags_t              flags,
    output logic [SEC_ID_W-1:0] hit
);
    localparam logic [CNT_W-1:0] LAST_SEC = CNT_W'(TRACK_SECTORS - 1);

    flags_t              fl_q;
    mode_e               mode_q;
    mode_e               req_mode;
    logic [CNT_W-1:0]    cnt_q;
    logic [SEC_ID_W-1:0] hit_q;

    always_comb req_mode = decode_mode(mode_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q   <= '0;
            mode_q <= MODE_EQ;
            cnt_q  <= '0;
            hit_q  <= '0;
        end else if (!fl_q.busy) begin
            if (start) begin
                if (req_mode == MODE_BAD) begin
                    fl_q.err   <= 1'b1;
                    fl_q.done  <= 1'b1;
                    fl_q.found <= 1'b0;
                end else begin
                    fl_q   <= '{busy: 1'b1, done: 1'b0, found: 1'b0, err: 1'b0};
                    mode_q <= req_mode;
                    cnt_q  <= '0;
                end
            end
        end else if (sec_end) begin
            if (rel_meets(mode_q, sec_rel)) begin
                fl_q.busy  <= 1'b0;
                fl_q.done  <= 1'b1;
                fl_q.found <= 1'b1;
                hit_q      <= sec_id;
            end else if (cnt_q == LAST_SEC) begin
                fl_q.busy <= 1'b0;
                fl_q.done <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign flags = fl_q;
    assign hit   = hit_q;
endmodule

// File: rtl/scan_cmp.sv
module scan_cmp
    import scan_cmp_pkg::*;
#(
    parameter int SECTOR_BYTES  = 256,
    parameter int TRACK_SECTORS = 24,
    parameter int SEC_ID_W      = 6,
    localparam int IDX_W        = $clog2(SECTOR_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_we,
    input  logic [IDX_W-1:0]    key_addr,
    input  logic [BYTE_W-1:0]   key_data,
    input  logic                scan_start,
    input  logic [BYTE_W-1:0]   scan_mode,
    input  logic                strm_valid,
    input  logic                strm_first,
    input  logic [SEC_ID_W-1:0] strm_sector,
    input  logic [BYTE_W-1:0]   strm_data,
    output logic                scan_busy,
    output logic                scan_done,
    output logic                scan_found,
    output logic                scan_err,
    output logic [SEC_ID_W-1:0] hit_sector
);
    logic [IDX_W-1:0]    rd_idx;
    logic [BYTE_W-1:0]   key_byte;
    logic                sec_end;
    rel_e                sec_rel;
    logic [SEC_ID_W-1:0] sec_id;
    flags_t              flags;

    scan_key_buf #(.DEPTH(SECTOR_BYTES)) u_key (
        .clk   (clk),
        .we    (key_we),
        .waddr (key_addr),
        .wdata (key_data),
        .raddr (rd_idx),
        .rdata (key_byte)
    );

    scan_sector_rel #(.SECTOR_BYTES(SECTOR_BYTES), .SEC_ID_W(SEC_ID_W)) u_rel (
        .clk       (clk),
        .rst       (rst),
        .enable    (flags.busy),
        .in_valid  (strm_valid),
        .in_first  (strm_first),
        .in_sector (strm_sector),
        .in_data   (strm_data),
        .key_byte  (key_byte),
        .key_idx   (rd_idx),
        .sec_end   (sec_end),
        .sec_rel   (sec_rel),
        .sec_id    (sec_id)
    );

    scan_ctrl #(.TRACK_SECTORS(TRACK_SECTORS), .SEC_ID_W(SEC_ID_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (scan_start),
        .mode_code (scan_mode),
        .sec_end   (sec_end),
        .sec_rel   (sec_rel),
        .sec_id    (sec_id),
        .flags     (flags),
        .hit       (hit_sector)
    );

    assign scan_busy  = flags.busy;
    assign scan_done  = flags.done;
    assign scan_found = flags.found;
    assign scan_err   = flags.err;
endmodule

// File: rtl/scan_cmp_chk.sv
module scan_cmp_chk #(
    parameter int SEC_ID_W = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                scan_start,
    input logic [7:0]          scan_mode,
    input logic                scan_busy,
    input logic                scan_done,
    input logic                scan_found,
    input logic                scan_err,
    input logic [SEC_ID_W-1:0] hit_sector
);
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!scan_busy && !scan_done && !scan_found && !scan_err));

    assert_bad_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (scan_start && !scan_busy && scan_mode > 8'd2)
        |=> (scan_err && scan_done && !scan_found && !scan_busy));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (scan_start && !scan_busy && scan_mode <= 8'd2)
        |=> (scan_busy && !scan_done && !scan_found && !scan_err));

    assert_found_implies_done_R8: assert property (@(posedge clk) disable iff (rst)
        scan_found |-> (scan_done && !scan_busy));

    assert_hit_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (scan_found && $past(scan_found)) |-> $stable(hit_sector));

    assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (rst)
        scan_busy |-> (!scan_done && !scan_err));

    assert_start_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (scan_busy && scan_start) |=> !scan_err);
endmodule

bind scan_cmp scan_cmp_chk #(.SEC_ID_W(SEC_ID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_start (scan_start),
    .scan_mode  (scan_mode),
    .scan_busy  (scan_busy),
    .scan_done  (scan_done),
    .scan_found (scan_found),
    .scan_err   (scan_err),
    .hit_sector (hit_sector)
);

// File: tb/scan_cmp_tb.sv
module scan_cmp_tb;
    localparam int NB = 256;
    localparam int NS = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_we = 1'b0;
    logic [7:0] key_addr = '0;
    logic [7:0] key_data = '0;
    logic       scan_start = 1'b0;
    logic [7:0] scan_mode = '0;
    logic       strm_valid = 1'b0;
    logic       strm_first = 1'b0;
    logic [5:0] strm_sector = '0;
    logic [7:0] strm_data = '0;
    logic       scan_busy, scan_done, scan_found, scan_err;
    logic [5:0] hit_sector;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] key_m [NB];
    logic [7:0] trk   [NS][NB];

    always #10 clk = ~clk;

    scan_cmp u_dut (
        .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr), .key_data(key_data),
        .scan_start(scan_start), .scan_mode(scan_mode), .strm_valid(strm_valid),
        .strm_first(strm_first), .strm_sector(strm_sector), .strm_data(strm_data),
        .scan_busy(scan_busy), .scan_done(scan_done), .scan_found(scan_found),
        .scan_err(scan_err), .hit_sector(hit_sector)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference: first sector index meeting the mode, or -1
    function automatic int exp_hit(input int mode);
        for (int s = 0; s < NS; s++) begin
            int r = 0;
            bit ok;
            for (int b = 0; b < NB; b++) begin
                if (r == 0 && key_m[b] != 8'hFF && trk[s][b] != key_m[b])
                    r = (trk[s][b] < key_m[b]) ? 1 : 2;
            end
            ok = (mode == 0) ? (r == 0) : (mode == 1) ? (r != 2) : (r != 1);
            if (ok) return s;
        end
        return -1;
    endfunction

    task automatic load_key();
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            key_we = 1'b1; key_addr = 8'(i); key_data = key_m[i];
        end
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic fill_random(input int ff_pct);
        for (int i = 0; i < NB; i++)
            key_m[i] = (($urandom % 100) < ff_pct) ? 8'hFF : 8'($urandom);
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < NB; b++) trk[s][b] = 8'($urandom);
    endtask

    task automatic plant_copy(input int s);
        for (int b = 0; b < NB; b++)
            trk[s][b] = (key_m[b] == 8'hFF) ? 8'($urandom) : key_m[b];
    endtask

    task automatic run_scan(input int mode, input int base, input bit poke_busy, input string tag);
        int e;
        e = exp_hit(mode);
        @(negedge clk);
        scan_start = 1'b1; scan_mode = 8'(mode);
        @(negedge clk);
        scan_start = 1'b0;
        check(scan_busy && !scan_done && !scan_found && !scan_err,
              {tag, " R10 start clears flags"},
              {scan_busy, scan_done, scan_found, scan_err}, 4'b1000);
        for (int s = 0; s < NS; s++) begin
            for (int b = 0; b < NB; b++) begin
                @(negedge clk);
                strm_valid  = 1'b1;
                strm_first  = (b == 0);
                strm_sector = 6'(base + s);
                strm_data   = trk[s][b];
                scan_start  = poke_busy && s == 1 && b == 10;
                scan_mode   = poke_busy ? 8'h03 : 8'(mode);
            end
            @(negedge clk);
            strm_valid = 1'b0; strm_first = 1'b0; scan_start = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        check(scan_done && !scan_busy, {tag, " R9 done at end"}, scan_done, 1);
        check(scan_found == (e >= 0), {tag, " R5/R6/R7 found"}, scan_found, (e >= 0));
        check(!scan_err, {tag, " R11 no error"}, scan_err, 0);
        if (e >= 0)
            check(hit_sector == 6'(base + e), {tag, " R8 hit sector"}, hit_sector, base + e);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!scan_busy && !scan_done && !scan_found && !scan_err, "R1 reset idle",
              {scan_busy, scan_done, scan_found, scan_err}, 0);

        // R2 rejected codes
        foreach (scan_mode[i]) ;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            scan_start = 1'b1; scan_mode = (k == 0) ? 8'h03 : 8'h80;
            @(negedge clk);
            scan_start = 1'b0;
            check(scan_err && scan_done && !scan_found && !scan_busy, "R2 bad mode",
                  {scan_busy, scan_done, scan_found, scan_err}, 4'b0101);
        end

        // R3 all-wildcard key matches first sector in every mode
        fill_random(100);
        load_key();
        for (int m = 0; m < 3; m++) run_scan(m, 32, 1'b0, "R3 all-FF");

        // R5 equal with planted matches at 7 and 15; R8 stops at first
        fill_random(25);
        plant_copy(7); plant_copy(15);
        load_key();
        run_scan(0, 32, 1'b0, "R5 equal planted");
        // R11 same track, busy poke with bad code
        run_scan(0, 0, 1'b1, "R11 poke while busy");

        // R9 no match
        fill_random(0);
        load_key();
        run_scan(0, 0, 1'b0, "R9 no match");

        // R4 first differing unmasked byte decides, unsigned
        for (int i = 0; i < NB; i++) key_m[i] = 8'h7F;
        key_m[0] = 8'hFF;
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < NB; b++) trk[s][b] = 8'h90;
        trk[4][0] = 8'h00; trk[4][1] = 8'h70;
        for (int b = 2; b < NB; b++) trk[4][b] = 8'hFF;
        load_key();
        run_scan(1, 0, 1'b0, "R4 R6 first diff LE");
        run_scan(2, 0, 1'b0, "R4 R7 first diff GE");
        check(hit_sector == 6'd0, "R7 GE hits sector 0", hit_sector, 0);

        // R6 R7 random
        for (int t = 0; t < 6; t++) begin
            fill_random(40);
            load_key();
            run_scan(1 + (t % 2), (t < 3) ? 0 : 32, 1'b0, "R6/R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule